// File: doc/BRIEF.md
# CPU Processing-State Sequencer

This block is the control state machine that decides which processing state a small 16-bit CPU core occupies. It has five states: reset, exception handling, program execution, bus released and program stop. Reset comes from an active-low pin or from a watchdog overflow pulse. Exception handling is a short two-cycle phase. In the first cycle it presents a vector index to the vector-table logic, and in the second it completes the branch before execution resumes.

While the core executes, the sequencer takes requests in a fixed order of precedence. A request from another bus master is handled first, then trace, trap and interrupt exceptions, then a sleep instruction or the hardware-standby input. In sleep, a pending interrupt or a wake-up event restarts the core through exception handling. The bus may also be lent to another master during sleep. Hardware standby can only be left through a reset. The outputs show the current state and give the interrupt mask, a vector strobe with its index, a bus grant and a core-halt enable.

Top module: `cpu_state_seq`

## Requirements
- R1: `state_oh` always has exactly one bit set, with the encoding bit 0 reset, bit 1 exception handling, bit 2 execution, bit 3 bus released, bit 4 stop.
- R2: Driving `rst_pin_n` low puts the block in the reset state at once, without waiting for a clock edge, from any state. In reset, `int_mask` and `core_halt` are high and `bus_ack` is low.
- R3: After `rst_pin_n` returns high, the first rising clock edge enters exception handling with vector index 0.
- R4: A `wdt_ovf` pulse sampled at a clock edge forces the reset state from any state and outranks every request except the pin. Reset then lasts `WDT_HOLD` cycles (default 8), after which exception handling starts with vector 0. A new pulse during the hold restarts the count.
- R5: Exception handling takes exactly two cycles. In the first, `vec_stb` is high with `vec_idx` valid. In the second, `vec_stb` is low. Execution follows. During these two cycles, bus, exception, sleep and standby requests are ignored.
- R6: In execution, exception requests are taken with the precedence trace (index 1), trap (index 2), interrupt (index 3 + `irq_src`).
- R7: A bus request in execution, or in sleep, moves the block to the bus-released state on the next edge. It stays there while the request is held and then returns to the state it came from. A bus request outranks any exception request.
- R8: In execution with no bus or exception request, `sleep_stb` or `stby_in` moves the block to the stop state.
- R9: In sleep, a pending interrupt enters exception handling with index 3 + `irq_src`. A wake-up event with no interrupt uses index 3. Trace and trap requests are ignored.
- R10: In hardware standby, interrupt, wake-up and bus requests have no effect. Only the pin or the watchdog leaves it. Raising `stby_in` while asleep turns sleep into standby.
- R11: `int_mask` is high exactly in reset and exception handling. `core_halt` is high exactly in reset, bus released and stop. `bus_ack` is high exactly in bus released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Active-low reset pin, asynchronous assert |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| trace_req | input | 1 | Trace exception request (level) |
| trap_req | input | 1 | Trap instruction exception request (level) |
| irq_req | input | 1 | Interrupt pending (level) |
| irq_src | input | SRC_W | Interrupt source number, added to the interrupt base index |
| ext_bus_req | input | 1 | Bus request from a non-CPU master (level) |
| sleep_stb | input | 1 | Sleep instruction executed |
| stby_in | input | 1 | Hardware standby request |
| wake_evt | input | 1 | Wake-up event for sleep |
| state_oh | output | 5 | One-hot processing state |
| int_mask | output | 1 | All interrupts masked |
| vec_stb | output | 1 | Vector fetch strobe |
| vec_idx | output | VEC_W | Vector index, valid with `vec_stb` |
| bus_ack | output | 1 | Bus granted to the other master |
| core_halt | output | 1 | Core must not execute |

## Verification
A wrong state register shows up on `state_oh` and on the derived mask, halt and grant outputs in the cycle right after the faulty edge. The reference model compares every cycle, so the failure is caught within one clock. A wrong vector choice shows on `vec_idx` in the strobe cycle. A shortened or lengthened watchdog hold shows as reset lasting one cycle too few or too many. A sleep/standby mix-up shows only when a wake-up or bus request arrives, so the stimulus sends those requests into both kinds of stop.

// File: rtl/pss_pkg.sv
package pss_pkg;

    localparam int unsigned NUM_STATES = 5;
    localparam int unsigned STATE_W    = 3;

    typedef enum logic [STATE_W-1:0] {
        PS_RESET  = 3'd0,
        PS_EXCEPT = 3'd1,
        PS_EXEC   = 3'd2,
        PS_BUSREL = 3'd3,
        PS_STOP   = 3'd4
    } pstate_e;

    localparam int unsigned VEC_RESET    = 0;
    localparam int unsigned VEC_TRACE    = 1;
    localparam int unsigned VEC_TRAP     = 2;
    localparam int unsigned VEC_IRQ_BASE = 3;

endpackage

// File: rtl/pss_hold_timer.sv
module pss_hold_timer #(
    parameter int unsigned HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int unsigned CNT_W = $clog2(HOLD + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CNT_W'(HOLD - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pss_vector_sel.sv
module pss_vector_sel #(
    parameter int unsigned VEC_W = 4,
    parameter int unsigned SRC_W = 3
) (
    input  logic             stopped,
    input  logic             trace_req,
    input  logic             trap_req,
    input  logic             irq_req,
    input  logic [SRC_W-1:0] irq_src,
    input  logic             wake_evt,
    output logic             take,
    output logic [VEC_W-1:0] idx
);
    import pss_pkg::*;

    logic [VEC_W-1:0] irq_idx;
    assign irq_idx = VEC_W'(VEC_IRQ_BASE) + VEC_W'(irq_src);

    always_comb begin
        take = 1'b0;
        idx  = VEC_W'(VEC_RESET);
        if (stopped) begin
            // only an interrupt or wake-up can leave sleep
            if (irq_req) begin
                take = 1'b1;
                idx  = irq_idx;
            end else if (wake_evt) begin
                take = 1'b1;
                idx  = VEC_W'(VEC_IRQ_BASE);
            end
        end else begin
            if (trace_req) begin
                take = 1'b1;
                idx  = VEC_W'(VEC_TRACE);
            end else if (trap_req) begin
                take = 1'b1;
                idx  = VEC_W'(VEC_TRAP);
            end else if (irq_req) begin
                take = 1'b1;
                idx  = irq_idx;
            end
        end
    end
endmodule

// File: rtl/pss_onehot_dec.sv
module pss_onehot_dec #(
    parameter int unsigned N  = 5,
    parameter int unsigned IW = 3
) (
    input  logic [IW-1:0] sel,
    output logic [N-1:0]  oh
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign oh[g] = (sel == IW'(g));
    end
endmodule

// File: rtl/cpu_state_seq.sv
module cpu_state_seq #(
    parameter int unsigned VEC_W    = 4,
    parameter int unsigned SRC_W    = 3,
    parameter int unsigned WDT_HOLD = 8
) (
    input  logic             clk,
    input  logic             rst_pin_n,
    input  logic             wdt_ovf,
    input  logic             trace_req,
    input  logic             trap_req,
    input  logic             irq_req,
    input  logic [SRC_W-1:0] irq_src,
    input  logic             ext_bus_req,
    input  logic             sleep_stb,
    input  logic             stby_in,
    input  logic             wake_evt,
    output logic [4:0]       state_oh,
    output logic             int_mask,
    output logic             vec_stb,
    output logic [VEC_W-1:0] vec_idx,
    output logic             bus_ack,
    output logic             core_halt
);
    import pss_pkg::*;

    typedef struct packed {
        pstate_e          st;
        logic             branch;  // second cycle of exception handling
        logic [VEC_W-1:0] vec;
        logic             stby;    // stop state is hardware standby
        pstate_e          ret;     // state to resume after bus release
    } seq_t;

    seq_t seq_d, seq_q;

    logic             hold_done;
    logic             exc_take;
    logic [VEC_W-1:0] exc_idx;
    logic             in_sleep;

    assign in_sleep = (seq_q.st == PS_STOP) && !seq_q.stby;

    pss_hold_timer #(.HOLD(WDT_HOLD)) u_hold (
        .clk     (clk),
        .rst_n   (rst_pin_n),
        .load    (wdt_ovf),
        .expired (hold_done)
    );

    pss_vector_sel #(.VEC_W(VEC_W), .SRC_W(SRC_W)) u_vsel (
        .stopped   (in_sleep),
        .trace_req (trace_req),
        .trap_req  (trap_req),
        .irq_req   (irq_req),
        .irq_src   (irq_src),
        .wake_evt  (wake_evt),
        .take      (exc_take),
        .idx       (exc_idx)
    );

    always_comb begin
        seq_d = seq_q;
        if (wdt_ovf) begin
            seq_d.st     = PS_RESET;
            seq_d.branch = 1'b0;
            seq_d.stby   = 1'b0;
        end else begin
            unique case (seq_q.st)
                PS_RESET: begin
                    if (hold_done) begin
                        seq_d.st     = PS_EXCEPT;
                        seq_d.branch = 1'b0;
                        seq_d.vec    = VEC_W'(VEC_RESET);
                    end
                end
                PS_EXCEPT: begin
                    if (!seq_q.branch) begin
                        seq_d.branch = 1'b1;
                    end else begin
                        seq_d.st     = PS_EXEC;
                        seq_d.branch = 1'b0;
                    end
                end
                PS_EXEC: begin
                    if (ext_bus_req) begin
                        seq_d.st  = PS_BUSREL;
                        seq_d.ret = PS_EXEC;
                    end else if (exc_take) begin
                        seq_d.st     = PS_EXCEPT;
                        seq_d.branch = 1'b0;
                        seq_d.vec    = exc_idx;
                    end else if (sleep_stb || stby_in) begin
                        seq_d.st   = PS_STOP;
                        seq_d.stby = stby_in;
                    end
                end
                PS_BUSREL: begin
                    if (!ext_bus_req) begin
                        seq_d.st = seq_q.ret;
                    end
                end
                PS_STOP: begin
                    if (!seq_q.stby) begin
                        if (ext_bus_req) begin
                            seq_d.st  = PS_BUSREL;
                            seq_d.ret = PS_STOP;
                        end else if (exc_take) begin
                            seq_d.st     = PS_EXCEPT;
                            seq_d.branch = 1'b0;
                            seq_d.vec    = exc_idx;
                        end else if (stby_in) begin
                            seq_d.stby = 1'b1;
                        end
                    end
                end
                default: begin
                    seq_d.st = PS_RESET;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            seq_q.st     <= PS_RESET;
            seq_q.branch <= 1'b0;
            seq_q.vec    <= VEC_W'(VEC_RESET);
            seq_q.stby   <= 1'b0;
            seq_q.ret    <= PS_EXEC;
        end else begin
            seq_q <= seq_d;
        end
    end

    pss_onehot_dec #(.N(NUM_STATES), .IW(STATE_W)) u_dec (
        .sel (seq_q.st),
        .oh  (state_oh)
    );

    assign int_mask  = (seq_q.st == PS_RESET) || (seq_q.st == PS_EXCEPT);
    assign vec_stb   = (seq_q.st == PS_EXCEPT) && !seq_q.branch;
    assign vec_idx   = seq_q.vec;
    assign bus_ack   = (seq_q.st == PS_BUSREL);
    assign core_halt = (seq_q.st == PS_RESET) || (seq_q.st == PS_BUSREL) ||
                       (seq_q.st == PS_STOP);
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
    parameter int unsigned VEC_W = 4
) (
    input logic             clk,
    input logic             rst_pin_n,
    input logic             wdt_ovf,
    input logic             trace_req,
    input logic             trap_req,
    input logic             irq_req,
    input logic             ext_bus_req,
    input logic             sleep_stb,
    input logic [4:0]       state_oh,
    input logic             int_mask,
    input logic             vec_stb,
    input logic [VEC_W-1:0] vec_idx,
    input logic             bus_ack,
    input logic             core_halt
);
    a_r1_one_state: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $countones(state_oh) == 1);

    a_r2_reset_masks: assert property (@(posedge clk) disable iff (!rst_pin_n)
        state_oh[0] |-> (int_mask && core_halt && !bus_ack));

    a_r4_wdt_forces_reset: assert property (@(posedge clk) disable iff (!rst_pin_n)
        wdt_ovf |=> state_oh[0]);

    a_r5_strobe_then_branch: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (vec_stb && !wdt_ovf) |=> (state_oh[1] && !vec_stb && $stable(vec_idx)));

    a_r5_branch_to_exec: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (state_oh[1] && !vec_stb && !wdt_ovf) |=> state_oh[2]);

    a_r7_grant_from_exec: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (state_oh[2] && ext_bus_req && !wdt_ovf) |=> bus_ack);

    a_r7_ack_halts: assert property (@(posedge clk) disable iff (!rst_pin_n)
        bus_ack |-> (core_halt && state_oh[3]));

    a_r8_sleep_enters_stop: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (state_oh[2] && sleep_stb && !ext_bus_req && !wdt_ovf &&
         !trace_req && !trap_req && !irq_req) |=> state_oh[4]);
endmodule

bind cpu_state_seq pss_checker #(.VEC_W(VEC_W)) u_pss_chk (
    .clk         (clk),
    .rst_pin_n   (rst_pin_n),
    .wdt_ovf     (wdt_ovf),
    .trace_req   (trace_req),
    .trap_req    (trap_req),
    .irq_req     (irq_req),
    .ext_bus_req (ext_bus_req),
    .sleep_stb   (sleep_stb),
    .state_oh    (state_oh),
    .int_mask    (int_mask),
    .vec_stb     (vec_stb),
    .vec_idx     (vec_idx),
    .bus_ack     (bus_ack),
    .core_halt   (core_halt)
);

// File: tb/tb_cpu_state_seq.sv
`timescale 1ns/1ps
module tb_cpu_state_seq;
    localparam int VEC_W = 4;
    localparam int SRC_W = 3;
    localparam int HOLD  = 8;

    logic             clk = 1'b0;
    logic             rst_pin_n = 1'b0;
    logic             wdt_ovf = 1'b0, trace_req = 1'b0, trap_req = 1'b0, irq_req = 1'b0;
    logic [SRC_W-1:0] irq_src = '0;
    logic             ext_bus_req = 1'b0, sleep_stb = 1'b0, stby_in = 1'b0, wake_evt = 1'b0;
    logic [4:0]       state_oh;
    logic             int_mask, vec_stb, bus_ack, core_halt;
    logic [VEC_W-1:0] vec_idx;

    always #4 clk = ~clk;

    cpu_state_seq #(.VEC_W(VEC_W), .SRC_W(SRC_W), .WDT_HOLD(HOLD)) dut (
        .clk(clk), .rst_pin_n(rst_pin_n), .wdt_ovf(wdt_ovf), .trace_req(trace_req),
        .trap_req(trap_req), .irq_req(irq_req), .irq_src(irq_src),
        .ext_bus_req(ext_bus_req), .sleep_stb(sleep_stb), .stby_in(stby_in),
        .wake_evt(wake_evt), .state_oh(state_oh), .int_mask(int_mask),
        .vec_stb(vec_stb), .vec_idx(vec_idx), .bus_ack(bus_ack), .core_halt(core_halt)
    );

    int checks = 0;
    int failures = 0;
    string cur_tag = "R2";

    // behavioural reference: 0 reset,1 exception,2 exec,3 bus released,4 stop
    int m_st = 0, m_br = 0, m_vec = 0, m_stby = 0, m_ret = 2, m_hold = 0;

    always @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            m_st = 0; m_br = 0; m_vec = 0; m_stby = 0; m_ret = 2; m_hold = 0;
        end else if (wdt_ovf) begin
            m_st = 0; m_hold = HOLD - 1; m_br = 0; m_stby = 0;
        end else begin
            case (m_st)
                0: if (m_hold == 0) begin m_st = 1; m_br = 0; m_vec = 0; end
                   else m_hold = m_hold - 1;
                1: if (m_br == 0) m_br = 1; else begin m_st = 2; m_br = 0; end
                2: if (ext_bus_req) begin m_ret = 2; m_st = 3; end
                   else if (trace_req) begin m_st = 1; m_br = 0; m_vec = 1; end
                   else if (trap_req) begin m_st = 1; m_br = 0; m_vec = 2; end
                   else if (irq_req) begin m_st = 1; m_br = 0; m_vec = 3 + int'(irq_src); end
                   else if (sleep_stb || stby_in) begin m_st = 4; m_stby = stby_in ? 1 : 0; end
                3: if (!ext_bus_req) m_st = m_ret;
                4: if (m_stby == 0) begin
                       if (ext_bus_req) begin m_ret = 4; m_st = 3; end
                       else if (irq_req) begin m_st = 1; m_br = 0; m_vec = 3 + int'(irq_src); end
                       else if (wake_evt) begin m_st = 1; m_br = 0; m_vec = 3; end
                       else if (stby_in) m_stby = 1;
                   end
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int exp_oh;
        int exp_stb;
        exp_oh  = 1 << m_st;
        exp_stb = (m_st == 1 && m_br == 0) ? 1 : 0;
        chk("R1", "onehot count", $countones(state_oh), 1);
        chk(cur_tag, "state_oh", int'(state_oh), exp_oh);
        chk(cur_tag, "vec_stb", int'(vec_stb), exp_stb);
        if (exp_stb == 1) chk(cur_tag, "vec_idx", int'(vec_idx), m_vec);
        chk("R11", "int_mask", int'(int_mask), (m_st == 0 || m_st == 1) ? 1 : 0);
        chk("R11", "core_halt", int'(core_halt), (m_st == 0 || m_st == 3 || m_st == 4) ? 1 : 0);
        chk("R11", "bus_ack", int'(bus_ack), (m_st == 3) ? 1 : 0);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic clear_in();
        wdt_ovf = 0; trace_req = 0; trap_req = 0; irq_req = 0;
        ext_bus_req = 0; sleep_stb = 0; stby_in = 0; wake_evt = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        cur_tag = "R2";
        compare();
        cyc(3);
        rst_pin_n = 1;
        cur_tag = "R3";
        cyc(1);
        chk("R3", "vec_idx after release", int'(vec_idx), 0);
        cur_tag = "R5";
        cyc(3);

        // R6: single and combined exception requests
        cur_tag = "R6";
        trace_req = 1; cyc(1); trace_req = 0; cyc(3);
        trap_req = 1; cyc(1); trap_req = 0; cyc(3);
        irq_src = 3'd5; irq_req = 1; cyc(1); irq_req = 0;
        chk("R6", "irq vector", int'(vec_idx), 8);
        cyc(3);
        trace_req = 1; trap_req = 1; irq_req = 1; cyc(1); clear_in(); cyc(3);
        trap_req = 1; irq_req = 1; cyc(1); clear_in(); cyc(3);

        // R7: bus outranks exception, returns to exec
        cur_tag = "R7";
        ext_bus_req = 1; irq_req = 1; irq_src = 3'd1; cyc(4);
        ext_bus_req = 0; cyc(1); cyc(1); irq_req = 0; cyc(3);

        // R5: requests during exception handling ignored
        cur_tag = "R5";
        trap_req = 1; cyc(1); trap_req = 0;
        ext_bus_req = 1; sleep_stb = 1; trace_req = 1; cyc(1);
        trace_req = 0; sleep_stb = 0; cyc(2); ext_bus_req = 0; cyc(2);

        // R8 / R9: sleep, bus lent in sleep, wake
        cur_tag = "R8";
        sleep_stb = 1; cyc(1); sleep_stb = 0; cyc(2);
        cur_tag = "R9";
        trap_req = 1; trace_req = 1; cyc(3); clear_in();
        cur_tag = "R7";
        ext_bus_req = 1; cyc(3); ext_bus_req = 0; cyc(2);
        cur_tag = "R9";
        wake_evt = 1; cyc(1); wake_evt = 0;
        chk("R9", "wake vector", int'(vec_idx), 3);
        cyc(3);
        sleep_stb = 1; cyc(1); sleep_stb = 0; cyc(1);
        irq_src = 3'd2; irq_req = 1; wake_evt = 1; cyc(1); clear_in(); cyc(3);

        // R10: hardware standby from exec
        cur_tag = "R10";
        stby_in = 1; cyc(1); stby_in = 0; cyc(1);
        irq_req = 1; wake_evt = 1; ext_bus_req = 1; cyc(4); clear_in();
        chk("R10", "still stopped", int'(state_oh), 16);
        cur_tag = "R4";
        wdt_ovf = 1; cyc(1); wdt_ovf = 0; cyc(HOLD + 4);

        // R10: sleep converted into standby
        cur_tag = "R10";
        sleep_stb = 1; cyc(1); sleep_stb = 0; cyc(1);
        stby_in = 1; cyc(1); stby_in = 0;
        wake_evt = 1; ext_bus_req = 1; cyc(3); clear_in(); cyc(1);

        // R4: watchdog from standby, restart during hold, during exception
        cur_tag = "R4";
        wdt_ovf = 1; cyc(1); wdt_ovf = 0; cyc(4);
        wdt_ovf = 1; ext_bus_req = 1; cyc(1); wdt_ovf = 0; ext_bus_req = 0;
        cyc(HOLD + 1);
        wdt_ovf = 1; cyc(1); wdt_ovf = 0; cyc(HOLD + 4);
        ext_bus_req = 1; cyc(2);
        wdt_ovf = 1; cyc(1); wdt_ovf = 0; ext_bus_req = 0; cyc(HOLD + 4);

        // R2: asynchronous pin reset while bus is released
        cur_tag = "R2";
        ext_bus_req = 1; cyc(2);
        rst_pin_n = 0;
        #1;
        chk("R2", "async reset state", int'(state_oh), 1);
        chk("R2", "async reset mask", int'(int_mask), 1);
        cyc(2);
        ext_bus_req = 0; rst_pin_n = 1;
        cur_tag = "R3";
        cyc(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule